// File: doc/BRIEF.md
# Optimal-Filter Energy and Timing Calculator

The block reconstructs a calorimeter pulse from five consecutive 16-bit samples of one channel. Each sample first has the channel pedestal subtracted. The block then forms the pulse energy as a weighted sum of these differences, using per-channel filter weights. When that energy is strictly above a threshold, the block makes two more passes over the same five differences. The first pass forms a weighted timing sum. The second pass forms a chi-square figure that measures how far the samples deviate from the scaled pulse shape of the channel.

A single signed multiply-accumulate unit (18 by 18 operands, 40-bit accumulator) does all the arithmetic. Events from many channels are processed one after another on this unit. The weight sets and the pedestals sit in per-channel register tables. A write port loads these tables, but only while the block is idle. Each result carries its channel tag and leaves in the order the events were accepted. An event that arrives while a computation is in progress is refused, and the refusal is flagged.

Top module: `ofc_calc`

## Requirements
- R1: The energy is E = sat32((Σ a_i·d_i) >>> 14) over the five taps i = 0..4. Here d_i = S_i − PED is a 17-bit signed difference. S_i sits in evt_smp_i[16i+15:16i], so tap 0 is in the low bits. The shift is an arithmetic shift, which rounds toward minus infinity.
- R2: Timing and quality are computed only when E is strictly greater than thr_i, read as a signed value and captured when the event is accepted. res_tvalid_o is then 1. When E equals the threshold, or is below it, res_tvalid_o is 0.
- R3: The timing result is T = sat32((Σ b_i·d_i) >>> 14).
- R4: The quality result is Q = sat32(Σ r_i²). Here r_i = sat18(d_i − ((sat18(E)·g_i) >>> 14)). Q saturates to 2147483647 and is never negative.
- R5: When res_tvalid_o is 0, res_time_o and res_chi2_o are both 0.
- R6: The cycle in which the event is accepted is cycle k. For an event below the threshold, res_valid_o pulses for one cycle after clock edge k+5. For an event above the threshold, the pulse comes after edge k+15. busy_o is high from the accept to the result. A new event can be accepted in the cycle in which res_valid_o is high.
- R7: If evt_valid_i is high while busy_o is high, the event is dropped. evt_reject_o goes high for the next cycle. The computation in progress is not affected.
- R8: A table write takes effect when cfg_we_i is high and busy_o is low. cfg_sel_i selects the table: 0 = a weights, 1 = b weights, 2 = g weights, 3 = pedestal (cfg_tap_i is ignored for the pedestal). A write while busy_o is high has no effect.
- R9: res_ch_o carries the channel of the event. Results leave in the order the events were accepted.
- R10: After reset, busy_o, evt_reject_o, res_valid_o, res_tvalid_o and every result field are 0, and all table entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | Table select: 0 a, 1 b, 2 g, 3 pedestal |
| cfg_ch_i | input | CH_W (3) | Channel to write |
| cfg_tap_i | input | TAP_W (3) | Tap to write (0..4) |
| cfg_data_i | input | 16 | Weight (signed Q1.14) or pedestal (unsigned) |
| thr_i | input | 32 | Signed energy threshold |
| evt_valid_i | input | 1 | Event present |
| evt_ch_i | input | CH_W (3) | Event channel |
| evt_smp_i | input | 80 | Five unsigned samples, tap 0 in the low bits |
| busy_o | output | 1 | Computation in progress |
| evt_reject_o | output | 1 | Previous-cycle event was refused |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_ch_o | output | CH_W (3) | Channel tag of the result |
| res_tvalid_o | output | 1 | Timing and quality are valid |
| res_energy_o | output | 32 | Energy, signed |
| res_time_o | output | 32 | Timing sum, signed |
| res_chi2_o | output | 32 | Chi-square, non-negative |

## Verification
The hardest situation to reach is a collision during the busy window. In it, a second event and a table write both arrive while a computation is running. The run must still finish with the old weights, and the new event must vanish without a trace. The stimulus reaches this with a directed sequence. It accepts an event, then one cycle later drives both a competing event and a write to a weight that the running pass is using. After that it checks the reject pulse, the values and tag of the first result, the absence of a second result, and a rerun that shows the weight was unchanged. The bench also makes the threshold equal to a computed energy exactly, which is the only way to exercise the strict comparison. It also saturates the chi-square with full-scale samples.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [1:0] {PH_E = 2'd0, PH_T = 2'd1, PH_Q = 2'd2} phase_e;
endpackage

// File: rtl/ofc_coef_tbl.sv
module ofc_coef_tbl #(
  parameter int N_CH  = 8,
  parameter int N_TAP = 5,
  parameter int W_W   = 16,
  parameter int CH_W  = 3,
  parameter int TAP_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [1:0]              sel_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [TAP_W-1:0]        wr_tap_i,
  input  logic [W_W-1:0]          wr_data_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  input  logic [TAP_W-1:0]        rd_tap_i,
  output logic signed [W_W-1:0]   a_o,
  output logic signed [W_W-1:0]   b_o,
  output logic signed [W_W-1:0]   g_o,
  output logic [W_W-1:0]          ped_o
);
  logic signed [W_W-1:0] a_q [N_CH][N_TAP];
  logic signed [W_W-1:0] b_q [N_CH][N_TAP];
  logic signed [W_W-1:0] g_q [N_CH][N_TAP];
  logic        [W_W-1:0] ped_q [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++) begin
        ped_q[c] <= '0;
        for (int t = 0; t < N_TAP; t++) begin
          a_q[c][t] <= '0;
          b_q[c][t] <= '0;
          g_q[c][t] <= '0;
        end
      end
    end else if (we_i) begin
      for (int c = 0; c < N_CH; c++) begin
        if (wr_ch_i == CH_W'(c)) begin
          if (sel_i == 2'd3) ped_q[c] <= wr_data_i;
          for (int t = 0; t < N_TAP; t++) begin
            if (wr_tap_i == TAP_W'(t)) begin
              if (sel_i == 2'd0) a_q[c][t] <= wr_data_i;
              if (sel_i == 2'd1) b_q[c][t] <= wr_data_i;
              if (sel_i == 2'd2) g_q[c][t] <= wr_data_i;
            end
          end
        end
      end
    end
  end

  assign a_o   = a_q[rd_ch_i][rd_tap_i];
  assign b_o   = b_q[rd_ch_i][rd_tap_i];
  assign g_o   = g_q[rd_ch_i][rd_tap_i];
  assign ped_o = ped_q[rd_ch_i];
endmodule

// File: rtl/ofc_opsel.sv
module ofc_opsel
  import ofc_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int W_W   = 16,
  parameter int OP_W  = 18,
  parameter int RES_W = 32,
  parameter int FRAC  = 14
) (
  input  phase_e                  phase_i,
  input  logic [SMP_W-1:0]        smp_i,
  input  logic [SMP_W-1:0]        ped_i,
  input  logic signed [W_W-1:0]   a_i,
  input  logic signed [W_W-1:0]   b_i,
  input  logic signed [W_W-1:0]   g_i,
  input  logic signed [RES_W-1:0] e_i,
  output logic signed [OP_W-1:0]  op_a_o,
  output logic signed [OP_W-1:0]  op_b_o
);
  localparam int RW = OP_W + W_W + 1;
  localparam logic signed [RW-1:0] OP_MAX = {{(RW-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
  localparam logic signed [RW-1:0] OP_MIN = {{(RW-OP_W+1){1'b1}}, {(OP_W-1){1'b0}}};

  function automatic logic signed [OP_W-1:0] sat_op(input logic signed [RW-1:0] v);
    if (v > OP_MAX)      return OP_MAX[OP_W-1:0];
    else if (v < OP_MIN) return OP_MIN[OP_W-1:0];
    else                 return v[OP_W-1:0];
  endfunction

  logic signed [SMP_W:0]        diff;
  logic signed [RW-1:0]         e_ext;
  logic signed [OP_W-1:0]       e_op;
  logic signed [OP_W+W_W-1:0]   shape;
  logic signed [OP_W+W_W-1:0]   shape_sc;
  logic signed [RW-1:0]         resid;
  logic signed [OP_W-1:0]       resid_op;

  assign diff     = $signed({1'b0, smp_i}) - $signed({1'b0, ped_i});
  assign e_ext    = e_i;
  assign e_op     = sat_op(e_ext);
  assign shape    = e_op * g_i;
  assign shape_sc = shape >>> FRAC;
  assign resid    = diff - shape_sc;
  assign resid_op = sat_op(resid);

  always_comb begin
    unique case (phase_i)
      PH_T: begin
        op_a_o = {{(OP_W-W_W){b_i[W_W-1]}}, b_i};
        op_b_o = {{(OP_W-SMP_W-1){diff[SMP_W]}}, diff};
      end
      PH_Q: begin
        op_a_o = resid_op;
        op_b_o = resid_op;
      end
      default: begin
        op_a_o = {{(OP_W-W_W){a_i[W_W-1]}}, a_i};
        op_b_o = {{(OP_W-SMP_W-1){diff[SMP_W]}}, diff};
      end
    endcase
  end
endmodule

// File: rtl/ofc_mac.sv
module ofc_mac #(
  parameter int OP_W  = 18,
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [OP_W-1:0]  op_a_i,
  input  logic signed [OP_W-1:0]  op_b_i,
  output logic signed [ACC_W-1:0] acc_nxt_o
);
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [2*OP_W-1:0] prod;

  assign prod      = op_a_i * op_b_i;
  assign acc_nxt_o = acc_q + prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/ofc_calc.sv
module ofc_calc
  import ofc_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int N_TAP = 5,
  parameter int SMP_W = 16,
  parameter int W_W   = 16,
  parameter int OP_W  = 18,
  parameter int ACC_W = 40,
  parameter int RES_W = 32,
  parameter int FRAC  = 14,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int TAP_W = $clog2(N_TAP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_sel_i,
  input  logic [CH_W-1:0]        cfg_ch_i,
  input  logic [TAP_W-1:0]       cfg_tap_i,
  input  logic [W_W-1:0]         cfg_data_i,
  input  logic [RES_W-1:0]       thr_i,
  input  logic                   evt_valid_i,
  input  logic [CH_W-1:0]        evt_ch_i,
  input  logic [N_TAP*SMP_W-1:0] evt_smp_i,
  output logic                   busy_o,
  output logic                   evt_reject_o,
  output logic                   res_valid_o,
  output logic [CH_W-1:0]        res_ch_o,
  output logic                   res_tvalid_o,
  output logic [RES_W-1:0]       res_energy_o,
  output logic [RES_W-1:0]       res_time_o,
  output logic [RES_W-1:0]       res_chi2_o
);
  localparam logic signed [ACC_W-1:0] R_MAX = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] R_MIN = {{(ACC_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};

  function automatic logic signed [RES_W-1:0] sat_res(input logic signed [ACC_W-1:0] v);
    if (v > R_MAX)      return R_MAX[RES_W-1:0];
    else if (v < R_MIN) return R_MIN[RES_W-1:0];
    else                return v[RES_W-1:0];
  endfunction

  logic                     busy_q;
  phase_e                   phase_q;
  logic [TAP_W-1:0]         tap_q;
  logic [CH_W-1:0]          ch_q;
  logic [SMP_W-1:0]         smp_q [N_TAP];
  logic signed [RES_W-1:0]  thr_q;
  logic signed [RES_W-1:0]  e_q;
  logic signed [RES_W-1:0]  t_q;

  logic signed [W_W-1:0]    a_w, b_w, g_w;
  logic [W_W-1:0]           ped_w;
  logic signed [OP_W-1:0]   op_a, op_b;
  logic signed [ACC_W-1:0]  acc_nxt, acc_sc;
  logic signed [RES_W-1:0]  sum_sat;
  logic                     last_tap, accept;

  assign last_tap = (tap_q == TAP_W'(N_TAP-1));
  assign accept   = evt_valid_i && !busy_q;
  assign acc_sc   = acc_nxt >>> FRAC;
  assign sum_sat  = sat_res(acc_sc);
  assign busy_o   = busy_q;

  ofc_coef_tbl #(.N_CH(N_CH), .N_TAP(N_TAP), .W_W(W_W), .CH_W(CH_W), .TAP_W(TAP_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && !busy_q), .sel_i(cfg_sel_i), .wr_ch_i(cfg_ch_i),
    .wr_tap_i(cfg_tap_i), .wr_data_i(cfg_data_i),
    .rd_ch_i(ch_q), .rd_tap_i(tap_q),
    .a_o(a_w), .b_o(b_w), .g_o(g_w), .ped_o(ped_w)
  );

  ofc_opsel #(.SMP_W(SMP_W), .W_W(W_W), .OP_W(OP_W), .RES_W(RES_W), .FRAC(FRAC)) u_opsel (
    .phase_i(phase_q), .smp_i(smp_q[tap_q]), .ped_i(ped_w),
    .a_i(a_w), .b_i(b_w), .g_i(g_w), .e_i(e_q),
    .op_a_o(op_a), .op_b_o(op_b)
  );

  ofc_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni,
    .clr_i(accept || (busy_q && last_tap)), .en_i(busy_q),
    .op_a_i(op_a), .op_b_i(op_b), .acc_nxt_o(acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      phase_q      <= PH_E;
      tap_q        <= '0;
      ch_q         <= '0;
      thr_q        <= '0;
      e_q          <= '0;
      t_q          <= '0;
      for (int i = 0; i < N_TAP; i++) smp_q[i] <= '0;
      evt_reject_o <= 1'b0;
      res_valid_o  <= 1'b0;
      res_ch_o     <= '0;
      res_tvalid_o <= 1'b0;
      res_energy_o <= '0;
      res_time_o   <= '0;
      res_chi2_o   <= '0;
    end else begin
      res_valid_o  <= 1'b0;
      evt_reject_o <= evt_valid_i && busy_q;
      if (accept) begin
        busy_q  <= 1'b1;
        phase_q <= PH_E;
        tap_q   <= '0;
        ch_q    <= evt_ch_i;
        thr_q   <= thr_i;
        for (int i = 0; i < N_TAP; i++) smp_q[i] <= evt_smp_i[i*SMP_W +: SMP_W];
      end else if (busy_q) begin
        if (!last_tap) begin
          tap_q <= tap_q + 1'b1;
        end else begin
          tap_q <= '0;
          unique case (phase_q)
            PH_E: begin
              e_q <= sum_sat;
              if (sum_sat > thr_q) begin
                phase_q <= PH_T;
              end else begin
                busy_q       <= 1'b0;
                res_valid_o  <= 1'b1;
                res_ch_o     <= ch_q;
                res_tvalid_o <= 1'b0;
                res_energy_o <= sum_sat;
                res_time_o   <= '0;
                res_chi2_o   <= '0;
              end
            end
            PH_T: begin
              t_q     <= sum_sat;
              phase_q <= PH_Q;
            end
            default: begin
              busy_q       <= 1'b0;
              res_valid_o  <= 1'b1;
              res_ch_o     <= ch_q;
              res_tvalid_o <= 1'b1;
              res_energy_o <= e_q;
              res_time_o   <= t_q;
              res_chi2_o   <= sat_res(acc_nxt);
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ofc_calc_chk.sv
module ofc_calc_chk #(
  parameter int RES_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             busy_o,
  input logic             evt_reject_o,
  input logic             res_valid_o,
  input logic             res_tvalid_o,
  input logic [RES_W-1:0] res_energy_o,
  input logic [RES_W-1:0] res_time_o,
  input logic [RES_W-1:0] res_chi2_o,
  input logic [RES_W-1:0] thr_q
);
  p_tv_above_thr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_tvalid_o |-> $signed(res_energy_o) > $signed(thr_q));

  p_low_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_tvalid_o |-> (res_time_o == '0) && (res_chi2_o == '0));

  p_chi2_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !res_chi2_o[RES_W-1]);

  p_reject_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_reject_o |-> $past(busy_o) && $past(evt_valid_i));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !busy_o);

  p_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && evt_valid_i |=> busy_o);
endmodule

bind ofc_calc ofc_calc_chk #(.RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .busy_o(busy_o),
  .evt_reject_o(evt_reject_o), .res_valid_o(res_valid_o), .res_tvalid_o(res_tvalid_o),
  .res_energy_o(res_energy_o), .res_time_o(res_time_o), .res_chi2_o(res_chi2_o),
  .thr_q(thr_q)
);

// File: tb/ofc_calc_tb.sv
`timescale 1ns/1ps
module ofc_calc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [2:0]  cfg_ch_i = '0;
  logic [2:0]  cfg_tap_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic [31:0] thr_i = '0;
  logic        evt_valid_i = 1'b0;
  logic [2:0]  evt_ch_i = '0;
  logic [79:0] evt_smp_i = '0;
  logic        busy_o, evt_reject_o, res_valid_o, res_tvalid_o;
  logic [2:0]  res_ch_o;
  logic [31:0] res_energy_o, res_time_o, res_chi2_o;

  int nchk = 0, nerr = 0;
  int wa[8][5], wb[8][5], wg[8][5], pd[8];

  always #10 clk_i = ~clk_i;

  ofc_calc u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(longint v, int bits);
    longint mx = (longint'(1) <<< (bits-1)) - 1;
    longint mn = -(longint'(1) <<< (bits-1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic void model(int ch, logic [79:0] smp, longint thr,
                                output longint e, output longint t, output longint q, output bit tv);
    longint d[5];
    longint acc, e18, r;
    for (int i = 0; i < 5; i++) d[i] = longint'(smp[i*16 +: 16]) - pd[ch];
    acc = 0;
    for (int i = 0; i < 5; i++) acc += wa[ch][i] * d[i];
    e = sat(acc >>> 14, 32);
    tv = (e > thr);
    t = 0; q = 0;
    if (tv) begin
      acc = 0;
      for (int i = 0; i < 5; i++) acc += wb[ch][i] * d[i];
      t = sat(acc >>> 14, 32);
      e18 = sat(e, 18);
      acc = 0;
      for (int i = 0; i < 5; i++) begin
        r = sat(d[i] - ((e18 * wg[ch][i]) >>> 14), 18);
        acc += r * r;
      end
      q = sat(acc, 32);
    end
  endfunction

  task automatic wr(int sel, int ch, int tap, int val);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_ch_i = 3'(ch);
    cfg_tap_i = 3'(tap); cfg_data_i = 16'(val);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    case (sel)
      0: wa[ch][tap] = int'($signed(16'(val)));
      1: wb[ch][tap] = int'($signed(16'(val)));
      2: wg[ch][tap] = int'($signed(16'(val)));
      default: pd[ch] = val & 16'hffff;
    endcase
  endtask

  task automatic check_res(string tag, int ch, logic [79:0] smp, longint thr, int lat);
    longint e, t, q;
    bit tv;
    model(ch, smp, thr, e, t, q, tv);
    chk({tag, " R6 latency"}, lat, tv ? 16 : 6);
    chk({tag, " R9 channel tag"}, res_ch_o, ch);
    chk({tag, " R2 tvalid"}, res_tvalid_o, tv);
    chk({tag, " R1 energy"}, longint'($signed(res_energy_o)), e);
    chk({tag, " R3/R5 time"}, longint'($signed(res_time_o)), t);
    chk({tag, " R4/R5 chi2"}, longint'($signed(res_chi2_o)), q);
  endtask

  task automatic run_evt(string tag, int ch, logic [79:0] smp, longint thr);
    int lat;
    thr_i = 32'(thr); evt_ch_i = 3'(ch); evt_smp_i = smp; evt_valid_i = 1'b1;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    lat = 1;
    while (!res_valid_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
    check_res(tag, ch, smp, thr, lat);
  endtask

  function automatic logic [79:0] rnd_smp(int ch);
    logic [79:0] v;
    for (int i = 0; i < 5; i++) begin
      int s = pd[ch] + int'($urandom_range(0, 24000)) - 3000;
      if (s < 0) s = 0;
      if (s > 65535) s = 65535;
      v[i*16 +: 16] = 16'(s);
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    longint e, t, q, thr;
    bit tv;
    logic [79:0] smp;
    void'($urandom(32'h0f17_2c5a));
    for (int c = 0; c < 8; c++) begin
      pd[c] = 0;
      for (int i = 0; i < 5; i++) begin wa[c][i] = 0; wb[c][i] = 0; wg[c][i] = 0; end
    end
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 busy", busy_o, 0);
    chk("R10 reject", evt_reject_o, 0);
    chk("R10 valid", res_valid_o, 0);
    chk("R10 tvalid", res_tvalid_o, 0);
    chk("R10 energy", res_energy_o, 0);
    chk("R10 chi2", res_chi2_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: empty tables give zero energy, zero threshold not exceeded
    run_evt("R10 empty tables", 2, {5{16'd1234}}, 0);

    // R8 load tables
    for (int c = 0; c < 8; c++) begin
      wr(3, c, 0, int'($urandom_range(100, 4000)));
      for (int i = 0; i < 5; i++) begin
        wr(0, c, i, int'($urandom_range(0, 32767)) - 16384);
        wr(1, c, i, int'($urandom_range(0, 32767)) - 16384);
        wr(2, c, i, int'($urandom_range(0, 32767)) - 16384);
      end
    end

    // random events, mixed thresholds, order and tags (R9)
    for (int n = 0; n < 60; n++) begin
      int ch = int'($urandom_range(0, 7));
      int k = int'($urandom_range(0, 2));
      thr = (k == 0) ? -64'sd2147483648 : (k == 1) ? 64'sd2147483647
                                                    : longint'(int'($urandom_range(0, 100000)) - 50000);
      run_evt("rand", ch, rnd_smp(ch), thr);
    end

    // R2 exact-threshold boundary
    smp = rnd_smp(4);
    model(4, smp, 0, e, t, q, tv);
    run_evt("R2 equal thr", 4, smp, e);
    run_evt("R2 thr minus one", 4, smp, e - 1);

    // R4 chi2 saturation: full-scale samples, zero pedestal and shape
    wr(3, 3, 0, 0);
    for (int i = 0; i < 5; i++) begin wr(0, 3, i, 16384); wr(2, 3, i, 0); end
    run_evt("R4 chi2 sat", 3, {5{16'hffff}}, -64'sd2147483648);
    chk("R4 chi2 saturated", longint'($signed(res_chi2_o)), 2147483647);

    // R1 negative energy, below threshold
    for (int i = 0; i < 5; i++) wr(0, 5, i, -16384);
    smp = rnd_smp(5);
    run_evt("R1 negative", 5, smp, 0);

    // R7/R8 collision: second event and table write while busy
    begin
      logic [79:0] s1 = rnd_smp(1);
      int old_a0 = wa[1][0];
      int guard;
      thr_i = 32'h8000_0000; evt_ch_i = 3'd1; evt_smp_i = s1; evt_valid_i = 1'b1;
      @(negedge clk_i);
      evt_valid_i = 1'b0;
      @(negedge clk_i);
      chk("R6 busy during run", busy_o, 1);
      evt_ch_i = 3'd6; evt_smp_i = rnd_smp(6); evt_valid_i = 1'b1;
      cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_ch_i = 3'd1; cfg_tap_i = 3'd0;
      cfg_data_i = 16'(old_a0 + 5000);
      @(negedge clk_i);
      evt_valid_i = 1'b0; cfg_we_i = 1'b0;
      chk("R7 reject pulse", evt_reject_o, 1);
      guard = 3;
      while (!res_valid_o && guard < 40) begin @(negedge clk_i); guard++; end
      check_res("R7/R8 busy collision", 1, s1, -64'sd2147483648, guard);
      chk("R7 reject cleared", evt_reject_o, 0);
      guard = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk_i);
        if (res_valid_o) guard++;
      end
      chk("R7 dropped event made no result", guard, 0);
      run_evt("R8 write while busy ignored", 1, s1, -64'sd2147483648);
    end

    // R8 pedestal write while idle changes energy
    wr(3, 0, 0, 0);
    run_evt("R8 pedestal zero", 0, rnd_smp(0), 64'sd2147483647);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule